// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small single-accumulator processor whose machine instructions are run by a microprogram held in an internal control store. Each machine word is 16 bits. The top 4 bits are the opcode and the low 12 bits are an operand address. The core reads instructions and operands through a simple memory port. The memory returns read data in the same cycle the read strobe is high, and a write happens at the clock edge that ends the strobe cycle.

The core has six registers:

- the accumulator;
- the program counter;
- a memory address register;
- a memory data register;
- a scratch register;
- the microprogram counter, together with the latched microword.

Every clock executes exactly one micro-operation. Register moves are limited to a few fixed paths. Incrementing the program counter uses the accumulator's adder. To make that possible, each instruction routine first parks the accumulator in the scratch register and restores it afterwards.

Top module: `ucode_acc_core`

## Requirements
- R1: A synchronous reset clears the accumulator and the program counter to 0 and sets the microprogram counter to 0. While reset is held, neither memory strobe is asserted.
- R2: Instruction fetch works as follows:
  - at microaddress 1, the read strobe is high and the memory address equals the program counter;
  - at microaddress 2, opcode n (1 to 6, held in bits 15:12 of the fetched word) sends the sequencer to microaddress 10·n;
  - the accumulator is unchanged during microaddresses 0 to 2.
- R3: Opcode 1 adds the memory word at the operand address (bits 11:0) to the accumulator, modulo 2^16. The program counter advances by 1.
- R4: Opcode 2 subtracts that word from the accumulator, modulo 2^16. The program counter advances by 1.
- R5: Opcode 3 loads that word into the accumulator. The program counter advances by 1.
- R6: Opcode 4 makes exactly one write of the accumulator value to the operand address. The accumulator is unchanged and the program counter advances by 1.
- R7: Opcode 5 sets the program counter to the operand address and leaves the accumulator unchanged.
- R8: Opcode 6 sets the program counter to the operand address when the accumulator is zero, and otherwise advances it by 1. The accumulator is unchanged in both cases.
- R9: Opcodes 0 and 7 to 15 have no effect except to advance the program counter by 1. They cause no memory write, and decoding one sends the sequencer to microaddress 70.
- R10: The program counter wraps from 0xFFF to 0x000.
- R11: Read and write strobes are never high together. Opcodes 1 to 3 make exactly two reads; every other instruction makes exactly one.
- R12: Instruction lengths in clocks, counting fetch, are:

  | Instruction | Clocks |
  |---|---|
  | Opcodes 1, 2, 3 | 13 |
  | Opcode 4 | 12 |
  | Opcode 5 | 5 |
  | Opcode 6, branch taken | 6 |
  | Opcode 6, branch not taken | 10 |
  | Undefined opcodes | 8 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Write data (data register) |
| mem_rdata | input | 16 | Read data, valid in the strobe cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| acc_q | output | 16 | Accumulator |
| pc_q | output | 12 | Program counter |
| uaddr_q | output | 8 | Microprogram counter |

## Verification
Two events can coincide in one adder cycle: the accumulator adder overflowing and its result becoming exactly zero. The conditional branch then has to act on the wrapped value. The bench provokes this by adding 0x0EBD to 0xF143, which gives 0x0000 with a carry out, and placing a conditional branch immediately afterwards. The branch must be taken, in 6 clocks, with the accumulator still 0. The same coincidence on the address side is covered by branching to 0xFFF: the next instruction's increment must both overflow the 12-bit counter and land on 0.

// File: rtl/ucac_pkg.sv
package ucac_pkg;

  localparam int UA_W = 8;
  localparam logic [UA_W-1:0] UA_FETCH = 8'd0;
  localparam logic [UA_W-1:0] UA_BUMP  = 8'd70;

  typedef enum logic [3:0] {
    UOP_NOP    = 4'd0,
    UOP_SAR_LD = 4'd1,   // address reg <- REG
    UOP_SDR_LD = 4'd2,   // data reg <- REG
    UOP_SDR_ST = 4'd3,   // REG <- data reg
    UOP_READ   = 4'd4,
    UOP_WRITE  = 4'd5,
    UOP_DECODE = 4'd6,
    UOP_JUMP   = 4'd7,
    UOP_SKIP   = 4'd8,
    UOP_ADD    = 4'd9,   // acc <- acc + REG
    UOP_SUB    = 4'd10,  // acc <- acc - REG
    UOP_LDACC  = 4'd11,  // acc <- REG
    UOP_STACC  = 4'd12,  // REG <- acc
    UOP_INCACC = 4'd13   // acc <- REG + 1
  } uop_e;

  typedef enum logic [1:0] {
    RS_ACC = 2'd0,
    RS_PC  = 2'd1,
    RS_TMP = 2'd2
  } rsel_e;

  typedef struct packed {
    uop_e             op;
    rsel_e            rs;
    logic [UA_W-1:0]  k;
  } uword_t;

  function automatic uword_t mk(input uop_e o, input rsel_e r, input logic [UA_W-1:0] k);
    uword_t w;
    w.op = o;
    w.rs = r;
    w.k  = k;
    return w;
  endfunction

  // start of the routine for an opcode; undefined codes share the pc-bump routine
  function automatic logic [UA_W-1:0] dec_target(input int unsigned opc);
    if (opc >= 1 && opc <= 6) return UA_W'(opc * 10);
    return UA_BUMP;
  endfunction

  // control store contents, computed per address
  function automatic uword_t cs_word(input logic [UA_W-1:0] a);
    uword_t w;
    int rt;
    int off;
    rt  = int'(a) / 10;
    off = int'(a) % 10;
    w   = mk(UOP_JUMP, RS_ACC, UA_FETCH);
    if (((rt >= 1 && rt <= 4) && off <= 5) || (rt == 7 && off <= 3)) begin
      // shared prologue: bump pc through the accumulator, then aim at operand
      case (off)
        0: w = mk(UOP_STACC,  RS_TMP, '0);
        1: w = mk(UOP_INCACC, RS_PC,  '0);
        2: w = mk(UOP_STACC,  RS_PC,  '0);
        3: w = mk(UOP_LDACC,  RS_TMP, '0);
        4: w = mk(UOP_SDR_ST, RS_TMP, '0);
        default: w = mk(UOP_SAR_LD, RS_TMP, '0);
      endcase
    end else begin
      case (rt)
        0: case (off)
             0: w = mk(UOP_SAR_LD, RS_PC,  '0);
             1: w = mk(UOP_READ,   RS_ACC, '0);
             2: w = mk(UOP_DECODE, RS_ACC, '0);
             default: ;
           endcase
        1, 2, 3: case (off)
             6: w = mk(UOP_READ,   RS_ACC, '0);
             7: w = mk(UOP_SDR_ST, RS_TMP, '0);
             8: w = mk((rt == 1) ? UOP_ADD : (rt == 2) ? UOP_SUB : UOP_LDACC, RS_TMP, '0);
             default: ;
           endcase
        4: case (off)
             6: w = mk(UOP_SDR_LD, RS_ACC, '0);
             7: w = mk(UOP_WRITE,  RS_ACC, '0);
             default: ;
           endcase
        5: if (off == 0) w = mk(UOP_SDR_ST, RS_PC, '0);
        6: case (off)
             0: w = mk(UOP_SKIP,   RS_ACC, '0);
             1: w = mk(UOP_JUMP,   RS_ACC, UA_BUMP);
             2: w = mk(UOP_SDR_ST, RS_PC,  '0);
             default: ;
           endcase
        default: ;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/ucac_ctrl_store.sv
module ucac_ctrl_store
  import ucac_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);

  always_comb word = cs_word(addr);

endmodule

// File: rtl/ucac_seq.sv
module ucac_seq
  import ucac_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  uword_t          rom_word,
  input  logic            decode_now,
  input  logic [OP_W-1:0] opcode,
  input  logic            acc_zero,
  output logic [UA_W-1:0] nxt_uaddr,
  output logic [UA_W-1:0] uaddr,
  output uword_t          mir
);

  always_comb begin
    if (rst) begin
      nxt_uaddr = UA_FETCH;
    end else if (decode_now) begin
      nxt_uaddr = dec_target(int'(opcode));
    end else begin
      case (mir.op)
        UOP_JUMP: nxt_uaddr = mir.k;
        UOP_SKIP: nxt_uaddr = uaddr + (acc_zero ? UA_W'(2) : UA_W'(1));
        default:  nxt_uaddr = uaddr + UA_W'(1);
      endcase
    end
  end

  // microword always matches the control address it was fetched from
  always_ff @(posedge clk) begin
    uaddr <= nxt_uaddr;
    mir   <= rom_word;
  end

endmodule

// File: rtl/ucac_datapath.sv
module ucac_datapath
  import ucac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  uop_e              op,
  input  rsel_e             rs,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sar,
  output logic [DATA_W-1:0] sdr,
  output logic [OP_W-1:0]   opcode,
  output logic              acc_zero,
  output logic              mem_rd,
  output logic              mem_wr
);

  localparam int PAD = DATA_W - ADDR_W;

  logic [DATA_W-1:0] tmp;
  logic [DATA_W-1:0] src;

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] f_sub(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DATA_W-1:0] f_inc(input logic [DATA_W-1:0] a);
    return a + DATA_W'(1);
  endfunction

  always_comb begin
    case (rs)
      RS_ACC:  src = acc;
      RS_PC:   src = {{PAD{1'b0}}, pc};
      default: src = tmp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      pc  <= '0;
      sar <= '0;
      sdr <= '0;
      tmp <= '0;
    end else begin
      case (op)
        UOP_SAR_LD: sar <= src[ADDR_W-1:0];
        UOP_SDR_LD: sdr <= src;
        UOP_SDR_ST: begin
          case (rs)
            RS_ACC:  acc <= sdr;
            RS_PC:   pc  <= sdr[ADDR_W-1:0];
            default: tmp <= sdr;
          endcase
        end
        UOP_READ:   sdr <= mem_rdata;
        UOP_ADD:    acc <= f_add(acc, src);
        UOP_SUB:    acc <= f_sub(acc, src);
        UOP_LDACC:  acc <= src;
        UOP_INCACC: acc <= f_inc(src);
        UOP_STACC: begin
          case (rs)
            RS_PC:   pc  <= acc[ADDR_W-1:0];
            RS_TMP:  tmp <= acc;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign opcode   = sdr[DATA_W-1 -: OP_W];
  assign acc_zero = (acc == '0);
  assign mem_rd   = (op == UOP_READ);
  assign mem_wr   = (op == UOP_WRITE);

endmodule

// File: rtl/ucode_acc_core.sv
module ucode_acc_core
  import ucac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] acc_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [UA_W-1:0]   uaddr_q
);

  uword_t            rom_word;
  uword_t            mir;
  logic [UA_W-1:0]   nxt_uaddr;
  logic [OP_W-1:0]   dec_opcode;
  logic              acc_zero;
  logic              ev_decode;

  assign ev_decode = (mir.op == UOP_DECODE);

  ucac_ctrl_store u_cs (
    .addr (nxt_uaddr),
    .word (rom_word)
  );

  ucac_seq #(.OP_W(OP_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .rom_word   (rom_word),
    .decode_now (ev_decode),
    .opcode     (dec_opcode),
    .acc_zero   (acc_zero),
    .nxt_uaddr  (nxt_uaddr),
    .uaddr      (uaddr_q),
    .mir        (mir)
  );

  ucac_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .op        (mir.op),
    .rs        (mir.rs),
    .mem_rdata (mem_rdata),
    .acc       (acc_q),
    .pc        (pc_q),
    .sar       (mem_addr),
    .sdr       (mem_wdata),
    .opcode    (dec_opcode),
    .acc_zero  (acc_zero),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

endmodule

// File: rtl/ucac_chk.sv
module ucac_chk
  import ucac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] acc_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [UA_W-1:0]   uaddr_q,
  input logic              ev_decode,
  input logic [OP_W-1:0]   dec_opcode
);

  logic opc_ok;
  assign opc_ok = (int'(dec_opcode) >= 1) && (int'(dec_opcode) <= 6);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R2
  fetch_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr_q == 8'd1) |-> (mem_rd && (mem_addr == pc_q)));

  // R2
  decode_map_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_decode && opc_ok) |=> (int'(uaddr_q) == int'($past(dec_opcode)) * 10));

  // R9
  decode_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_decode && !opc_ok) |=> (uaddr_q == UA_BUMP));

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == acc_q));

  // R2
  fetch_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr_q <= 8'd2) |=> $stable(acc_q));

endmodule

bind ucode_acc_core ucac_chk #(.DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .acc_q      (acc_q),
  .pc_q       (pc_q),
  .uaddr_q    (uaddr_q),
  .ev_decode  (ev_decode),
  .dec_opcode (dec_opcode)
);

// File: tb/sim_ucode_acc_core.sv
module sim_ucode_acc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] acc_q;
  logic [11:0] pc_q;
  logic [7:0]  uaddr_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] mem [0:255];

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  ucode_acc_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .acc_q(acc_q), .pc_q(pc_q), .uaddr_q(uaddr_q)
  );

  // {opcode, operand addr, operand value, expected acc, expected pc, expected clocks}
  localparam logic [67:0] VEC [0:17] = '{
    {4'h3, 12'h080, 16'h1234, 16'h1234, 12'h001, 8'd13},
    {4'h1, 12'h081, 16'h0F0F, 16'h2143, 12'h002, 8'd13},
    {4'h2, 12'h082, 16'h3000, 16'hF143, 12'h003, 8'd13},
    {4'h4, 12'h083, 16'h0000, 16'hF143, 12'h004, 8'd12},
    {4'h6, 12'h020, 16'h0000, 16'hF143, 12'h005, 8'd10},
    {4'h5, 12'h030, 16'h0000, 16'hF143, 12'h030, 8'd5},
    {4'h1, 12'h084, 16'h0EBD, 16'h0000, 12'h031, 8'd13},
    {4'h6, 12'h040, 16'h0000, 16'h0000, 12'h040, 8'd6},
    {4'h0, 12'h085, 16'h7777, 16'h0000, 12'h041, 8'd8},
    {4'hF, 12'h086, 16'h7777, 16'h0000, 12'h042, 8'd8},
    {4'h3, 12'h087, 16'hFFFF, 16'hFFFF, 12'h043, 8'd13},
    {4'h2, 12'h088, 16'hFFFF, 16'h0000, 12'h044, 8'd13},
    {4'h2, 12'h089, 16'h0001, 16'hFFFF, 12'h045, 8'd13},
    {4'h5, 12'hFFF, 16'h0000, 16'hFFFF, 12'hFFF, 8'd5},
    {4'h3, 12'h08A, 16'h0055, 16'h0055, 12'h000, 8'd13},
    {4'h4, 12'h08B, 16'h0000, 16'h0055, 12'h001, 8'd12},
    {4'h6, 12'h010, 16'h0000, 16'h0055, 12'h002, 8'd10},
    {4'h1, 12'h08D, 16'h0000, 16'h0055, 12'h003, 8'd13}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // run one instruction from a negedge where the microprogram counter is 0
  task automatic exec(input logic [11:0] mpc, output int cyc, output int nwr, output int nrd,
                      output logic [11:0] wa, output logic [15:0] wd);
    bit fchk = 0;
    cyc = 0; nwr = 0; nrd = 0; wa = '0; wd = '0;
    do begin
      if (mem_rd) nrd++;
      if (mem_wr) begin nwr++; wa = mem_addr; wd = mem_wdata; end
      if (mem_rd && mem_wr) chk("R11", "strobe overlap", 1, 0);
      if (uaddr_q == 8'd1 && !fchk) begin
        fchk = 1;
        chk("R2", "fetch strobe/addr", {19'd0, mem_rd, mem_addr}, {19'd0, 1'b1, mpc});
      end
      @(posedge clk); cyc++; @(negedge clk);
    end while (uaddr_q != 8'd0 && cyc < 64);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] mpc;
    int cyc, nwr, nrd;
    logic [11:0] wa;
    logic [15:0] wd;
    for (int j = 0; j < 256; j++) mem[j] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "acc at reset", acc_q, 0);
    chk("R1", "pc at reset", pc_q, 0);
    chk("R1", "uaddr at reset", uaddr_q, 0);
    chk("R1", "strobes at reset", {mem_rd, mem_wr}, 0);
    mpc = 12'h000;
    mem[0] = {VEC[0][67:64], VEC[0][63:52]};
    mem[VEC[0][59:52]] = VEC[0][51:36];
    rst = 1'b0;
    for (int i = 0; i < 18; i++) begin
      logic [3:0]  op;
      logic [11:0] a;
      logic [15:0] opnd, eacc;
      logic [11:0] epc;
      logic [7:0]  ecyc;
      {op, a, opnd, eacc, epc, ecyc} = VEC[i];
      mem[mpc[7:0]] = {op, a};
      if (op != 4'h5 && op != 4'h6) mem[a[7:0]] = opnd;
      exec(mpc, cyc, nwr, nrd, wa, wd);
      chk(req_of(op), "acc", acc_q, eacc);
      chk(req_of(op), "pc", pc_q, epc);
      chk("R12", "clocks", cyc, ecyc);
      chk("R11", "read count", nrd, (op >= 4'h1 && op <= 4'h3) ? 2 : 1);
      chk(req_of(op), "write count", nwr, (op == 4'h4) ? 1 : 0);
      if (op == 4'h4) begin
        chk("R6", "write addr", wa, a);
        chk("R6", "write data", wd, eacc);
        chk("R6", "stored word", mem[a[7:0]], eacc);
      end
      if (i == 14) chk("R10", "pc wrap", pc_q, 12'h000);
      mpc = epc;
    end
    // R1: reset in the middle of an add
    mem[mpc[7:0]] = {4'h1, 12'h08D};
    repeat (8) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "acc after mid reset", acc_q, 0);
    chk("R1", "pc after mid reset", pc_q, 0);
    chk("R1", "uaddr after mid reset", uaddr_q, 0);
    mem[0] = {4'h3, 12'h08E};
    mem[8'h8E] = 16'h0ABC;
    rst = 1'b0;
    exec(12'h000, cyc, nwr, nrd, wa, wd);
    chk("R5", "acc after restart", acc_q, 16'h0ABC);
    chk("R5", "pc after restart", pc_q, 12'h001);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule